// File: doc/BRIEF.md
# Gapped Read-Enable Generator with Fill-Driven Justification

This block runs on a fixed, free-running output clock in a transmitter that carries a plesiochronous payload into a framed outgoing stream. On every cycle it decides whether a payload word is taken from an elastic FIFO (`read_en`) or whether the slot is left empty. An empty slot is either the scheduled overhead slot that closes each gap period, or an unplanned justification slot. Gapping is a synchronous qualifier on the base clock; the clock net itself is never gated. Every slot is therefore whole: it is either a read or it is not.

A gap period of `n_eff` cycles holds `n_eff-1` read slots followed by one overhead slot. The average read rate is therefore (N-1)/N of the base clock. A 100 MHz base clock with N=100 gives a 99 MHz average. The period length adapts to the FIFO fill status at each period boundary. A nearly empty FIFO shortens the period, so more read pulses are removed and the FIFO refills. A nearly full FIFO lengthens it, so fewer are removed and the FIFO drains. The period never leaves the configured minimum/maximum window. If the FIFO reports empty, the read in that slot is withheld and the slot is flagged as justification. The output clock must exceed the payload rate plus the overhead by at least the worst-case drift between the two clocks, and the N window is chosen to cover that margin.

Top module: `gap_enable_gen`

## Requirements
- R1: Outside reset, exactly one of `read_en`, `ovh_slot` and `just_slot` is high in every cycle.
- R2: With the FIFO never empty and `n_eff` constant, slot index N-1 of each period (counting from 0) is an overhead slot. The other N-1 slots assert `read_en`.
- R3: On synchronous reset, `n_eff` loads `cfg_n_nom` clamped into [`cfg_n_min`, `cfg_n_max`]. The configuration must satisfy 2 <= `cfg_n_min` <= `cfg_n_max`.
- R4: At the clock edge that ends a period, if `fifo_almost_empty` is high and `n_eff` > `cfg_n_min`, then `n_eff` drops by exactly one. Otherwise it is held at or above the minimum.
- R5: At a period end, if `fifo_almost_full` is high, `fifo_almost_empty` is low and `n_eff` < `cfg_n_max`, then `n_eff` rises by one. It never exceeds the maximum.
- R6: When both status inputs are high at a period end, the almost-empty rule wins.
- R7: `n_eff` changes only at a period end. With neither status input high, it is held.
- R8: `read_en` is low in any cycle where `fifo_empty` is high. Such a slot raises `just_slot`, unless it is the overhead slot, in which case only `ovh_slot` is high. An empty FIFO does not shift the slot pattern and does not alter `n_eff`.
- R9: While `rst` is high, all three slot outputs are low. After release, the slot count restarts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running output clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_n_nom | input | 8 | Nominal gap period in cycles |
| cfg_n_min | input | 8 | Lower bound of the gap period |
| cfg_n_max | input | 8 | Upper bound of the gap period |
| fifo_almost_empty | input | 1 | FIFO nearing empty, synchronized to clk |
| fifo_almost_full | input | 1 | FIFO nearing full, synchronized to clk |
| fifo_empty | input | 1 | FIFO empty, synchronized to clk |
| read_en | output | 1 | Read one payload word this cycle |
| ovh_slot | output | 1 | Scheduled overhead slot (period end) |
| just_slot | output | 1 | Extra justification slot forced by an empty FIFO |
| n_eff | output | 8 | Current effective gap period |

## Verification
An empty FIFO can coincide with the scheduled overhead slot. In that cycle both the empty guard and the gap schedule want the read withheld, and only one flag may rise. The bench raises `fifo_empty` exactly in a period's last slot and in a mid-period slot. It expects `ovh_slot` alone in the first case and `just_slot` alone in the second. It then confirms that the next overhead slot lands where the unshifted count predicts. The second collision is between almost-empty and almost-full at the same period end. The bench drives both together and judges that the period shrinks, counting reads and reading `n_eff` after a known number of whole periods.

// File: rtl/gap_pkg.sv
package gap_pkg;
  localparam int unsigned NW = 8;
  typedef logic [NW-1:0] nval_t;

  function automatic nval_t clamp_n(nval_t n, nval_t mn, nval_t mx);
    if (n < mn) return mn;
    if (n > mx) return mx;
    return n;
  endfunction

  // Period length for the next period, chosen at a period boundary.
  function automatic nval_t next_n(nval_t n, logic lo, logic hi, nval_t mn, nval_t mx);
    nval_t r;
    if (lo && n > mn)             r = n - 1'b1;
    else if (!lo && hi && n < mx) r = n + 1'b1;
    else                          r = n;
    return clamp_n(r, mn, mx);
  endfunction

  // True when slot index pos is the last slot of an n-cycle period.
  function automatic logic last_slot(nval_t pos, nval_t n);
    return ({1'b0, pos} + 1'b1) >= {1'b0, n};
  endfunction
endpackage

// File: rtl/gap_period_ctrl.sv
module gap_period_ctrl
  import gap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wrap,
  input  logic  lo_fill,
  input  logic  hi_fill,
  input  nval_t n_nom,
  input  nval_t n_min,
  input  nval_t n_max,
  output nval_t n_cur
);
  always_ff @(posedge clk) begin
    if (rst)       n_cur <= clamp_n(n_nom, n_min, n_max);
    else if (wrap) n_cur <= next_n(n_cur, lo_fill, hi_fill, n_min, n_max);
  end
endmodule

// File: rtl/gap_slot_counter.sv
module gap_slot_counter
  import gap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  nval_t n_cur,
  output logic  wrap
);
  nval_t pos;

  assign wrap = !rst && last_slot(pos, n_cur);

  always_ff @(posedge clk) begin
    if (rst)       pos <= '0;
    else if (wrap) pos <= '0;
    else           pos <= pos + 1'b1;
  end
endmodule

// File: rtl/gap_enable_gen.sv
module gap_enable_gen
  import gap_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] cfg_n_nom,
  input  logic [NW-1:0] cfg_n_min,
  input  logic [NW-1:0] cfg_n_max,
  input  logic          fifo_almost_empty,
  input  logic          fifo_almost_full,
  input  logic          fifo_empty,
  output logic          read_en,
  output logic          ovh_slot,
  output logic          just_slot,
  output logic [NW-1:0] n_eff
);
  logic wrap;        // last slot of the current period
  logic data_slot;   // slot scheduled to carry payload

  gap_period_ctrl u_period (
    .clk     (clk),
    .rst     (rst),
    .wrap    (wrap),
    .lo_fill (fifo_almost_empty),
    .hi_fill (fifo_almost_full),
    .n_nom   (cfg_n_nom),
    .n_min   (cfg_n_min),
    .n_max   (cfg_n_max),
    .n_cur   (n_eff)
  );

  gap_slot_counter u_slots (
    .clk   (clk),
    .rst   (rst),
    .n_cur (n_eff),
    .wrap  (wrap)
  );

  assign data_slot = !rst && !wrap;
  assign ovh_slot  = wrap;
  assign read_en   = data_slot && !fifo_empty;
  assign just_slot = data_slot && fifo_empty;
endmodule

// File: rtl/gap_enable_chk.sv
module gap_enable_chk
  import gap_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input nval_t cfg_n_min,
  input nval_t cfg_n_max,
  input logic  fifo_almost_empty,
  input logic  fifo_almost_full,
  input logic  fifo_empty,
  input logic  read_en,
  input logic  ovh_slot,
  input logic  just_slot,
  input nval_t n_eff,
  input logic  wrap
);
  a_r1_one_kind: assert property (@(posedge clk) disable iff (rst)
    $countones({read_en, ovh_slot, just_slot}) == 1);

  a_r2_gap_at_end: assert property (@(posedge clk) disable iff (rst)
    wrap |-> (ovh_slot && !read_en));

  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (wrap && fifo_almost_empty && n_eff > cfg_n_min && n_eff <= cfg_n_max)
      |=> n_eff == $past(n_eff) - 1'b1);

  a_r5_step_up: assert property (@(posedge clk) disable iff (rst)
    (wrap && !fifo_almost_empty && fifo_almost_full && n_eff < cfg_n_max && n_eff >= cfg_n_min)
      |=> n_eff == $past(n_eff) + 1'b1);

  a_r7_hold_mid: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wrap)) |-> $stable(n_eff));

  a_r8_no_read_empty: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !read_en);

  a_r8_just_flag: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && !wrap) |-> just_slot);

  always_comb begin
    if (rst) a_r9_idle: assert (!read_en && !ovh_slot && !just_slot);
  end
endmodule

bind gap_enable_gen gap_enable_chk chk_i (.*);

// File: tb/gap_enable_gen_tb_top.sv
`timescale 1ns/1ps
module gap_enable_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_n_nom = 8'd10, cfg_n_min = 8'd4, cfg_n_max = 8'd16;
  logic       fifo_almost_empty = 1'b0, fifo_almost_full = 1'b0, fifo_empty = 1'b0;
  logic       read_en, ovh_slot, just_slot;
  logic [7:0] n_eff;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gap_enable_gen dut_i (
    .clk(clk), .rst(rst),
    .cfg_n_nom(cfg_n_nom), .cfg_n_min(cfg_n_min), .cfg_n_max(cfg_n_max),
    .fifo_almost_empty(fifo_almost_empty), .fifo_almost_full(fifo_almost_full),
    .fifo_empty(fifo_empty),
    .read_en(read_en), .ovh_slot(ovh_slot), .just_slot(just_slot), .n_eff(n_eff)
  );

  typedef struct packed {
    int unsigned nom, mn, mx;
    bit          lo, hi;
    int unsigned cyc, reads, ovh, nfin;
  } vec_t;

  // Each row runs a whole number of periods from reset; expected values
  // follow from summing period lengths by hand.
  localparam vec_t VECS [6] = '{
    '{10, 4, 16, 1'b0, 1'b0, 100, 90, 10, 10}, // R2 R7 steady
    '{10, 4, 16, 1'b1, 1'b0,  45, 39,  6,  4}, // R4 10..5 then floor
    '{10, 4, 12, 1'b0, 1'b1,  45, 41,  4, 12}, // R5 10,11,12,12
    '{ 8, 4, 12, 1'b1, 1'b1,  15, 13,  2,  6}, // R6 lo wins
    '{20, 4, 16, 1'b0, 1'b0,  32, 30,  2, 16}, // R3 clamp to max
    '{ 2, 2,  2, 1'b1, 1'b0,  20, 10, 10,  2}  // R4 at floor
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R2 R7";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(int nom, int mn, int mx);
    rst = 1'b1;
    fifo_almost_empty = 1'b0; fifo_almost_full = 1'b0; fifo_empty = 1'b0;
    cfg_n_nom = 8'(nom); cfg_n_min = 8'(mn); cfg_n_max = 8'(mx);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    int n = 0;
    while (!done && n < 100000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", n, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int reads, ovh, just, oob;
    // R9: outputs idle in reset
    repeat (2) @(negedge clk);
    #1;
    check(!read_en && !ovh_slot && !just_slot, "R9", "idle in reset",
          {read_en, ovh_slot, just_slot}, 0);

    for (int i = 0; i < 6; i++) begin
      do_reset(VECS[i].nom, VECS[i].mn, VECS[i].mx);
      fifo_almost_empty = VECS[i].lo;
      fifo_almost_full  = VECS[i].hi;
      reads = 0; ovh = 0; just = 0; oob = 0;
      for (int c = 0; c < int'(VECS[i].cyc); c++) begin
        #1;
        if (read_en) reads++;
        if (ovh_slot) ovh++;
        if (just_slot) just++;
        if (int'(n_eff) < int'(VECS[i].mn) || int'(n_eff) > int'(VECS[i].mx)) oob++;
        if ($countones({read_en, ovh_slot, just_slot}) != 1) oob++;
        @(negedge clk);
      end
      #1;
      check(reads == int'(VECS[i].reads), vec_tag(i), "read count", reads, VECS[i].reads);
      check(ovh == int'(VECS[i].ovh), vec_tag(i), "overhead count", ovh, VECS[i].ovh);
      check(int'(n_eff) == int'(VECS[i].nfin), vec_tag(i), "final period", n_eff, VECS[i].nfin);
      check(oob == 0 && just == 0, "R1", "slot kind / bounds errors", oob + just, 0);
    end

    // R8: empty in a data slot and in the overhead slot, N=5
    do_reset(5, 2, 8);
    #1;
    check(read_en && !ovh_slot, "R9", "slot 0 after release reads", read_en, 1);
    repeat (2) @(negedge clk);          // slot 2
    fifo_empty = 1'b1;
    #1;
    check(!read_en, "R8", "no read while empty", read_en, 0);
    check(just_slot && !ovh_slot, "R8", "justification flag", just_slot, 1);
    @(negedge clk); fifo_empty = 1'b0;  // slot 3
    #1;
    check(read_en, "R8", "read resumes", read_en, 1);
    @(negedge clk); fifo_empty = 1'b1;  // slot 4, overhead slot
    #1;
    check(ovh_slot && !just_slot && !read_en, "R8", "empty on overhead slot",
          {read_en, ovh_slot, just_slot}, 3'b010);
    @(negedge clk); fifo_empty = 1'b0;
    repeat (4) @(negedge clk);          // slot 4 of second period
    #1;
    check(ovh_slot, "R8", "pattern unshifted", ovh_slot, 1);
    check(n_eff == 8'd5, "R8", "period unchanged by empty", n_eff, 5);

    // R9: reset mid-period restarts count
    repeat (3) @(negedge clk);          // slot 2
    rst = 1'b1;
    #1;
    check(!read_en && !ovh_slot && !just_slot, "R9", "idle when reset asserted",
          {read_en, ovh_slot, just_slot}, 0);
    @(negedge clk); rst = 1'b0;          // slot 0
    repeat (3) @(negedge clk);           // slot 3
    #1;
    check(read_en && !ovh_slot, "R9", "slot 3 after restart reads", read_en, 1);
    @(negedge clk);                      // slot 4
    #1;
    check(ovh_slot, "R9", "overhead at slot 4 after restart", ovh_slot, 1);

    // R7: period held when status returns quiet
    do_reset(6, 2, 8);
    fifo_almost_full = 1'b1;
    repeat (6) @(negedge clk);
    fifo_almost_full = 1'b0;
    #1;
    check(n_eff == 8'd7, "R5", "one step up", n_eff, 7);
    repeat (21) @(negedge clk);
    #1;
    check(n_eff == 8'd7, "R7", "held with quiet status", n_eff, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule